// File: doc/BRIEF.md
# Bit-Plane Transposing Buffer

This block takes a stream of 8-bit words and returns the same data regrouped by bit position. After a frame of `DEPTH` words has been written, the block produces 32-bit output words. Each output word carries a single bit position taken from 32 consecutive input words. The most significant bit position is read out first, then each lower position in turn, down to bit 0.

Storage is organised as eight one-bit-wide planes, one for each input bit position. An accepted input word scatters its eight bits into the eight planes at the same bit address. A read takes 32 adjacent bits from a single plane.

Two such buffers alternate roles. One fills with the next frame while the other is drained. Both stream edges use valid/ready handshakes:

- A word moves on the input side in a cycle where `in_valid` and `in_ready` are both high.
- A word moves on the output side in a cycle where `out_valid` and `out_ready` are both high.
- The producer sees back-pressure through `in_ready`. The consumer exerts back-pressure through `out_ready`. The output holds its word for as long as it is not taken.

Top module: `bitplane_transposer`

## Requirements
- R1: While the synchronous active-high reset is applied and in the cycle after, `in_ready` is 1, `out_valid` is 0 and `frame_done` is 0.
- R2: Input words are numbered 0 to `DEPTH`-1 within a frame, in acceptance order. Output word k of a bit pass has bit j equal to the pass's bit position of input word 32k+j.
- R3: A frame yields 8*`DEPTH`/32 output words. The first `DEPTH`/32 words carry bit 7, the next `DEPTH`/32 carry bit 6, and so on, with bit 0 last.
- R4: `in_ready` stays high until `DEPTH` words of a frame have been accepted. It falls in the next cycle and stays low while the other buffer is still being drained.
- R5: Frames come out in the order they were written, with none lost. A new frame can be accepted in the same cycles in which the previous one is being read out.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R7: `frame_done` is high for exactly one cycle. That cycle immediately follows the acceptance of the last output word of a frame, and `frame_done` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_data | input | 8 | Input word |
| in_ready | output | 1 | Block can take an input word |
| out_valid | output | 1 | Output bit-plane word available |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Bit-plane word; bit j belongs to input word 32k+j |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame is taken |

## Verification
The bench first stalls the consumer for a long stretch, so that both buffers fill. `in_ready` must then drop and the first output word must be held. A design that swapped buffers too early would overwrite a frame that has not been read yet. A design that ignored the stall would skip or change words.

Words are compared bit by bit against a transposition computed in the bench. This comparison exposes a reversed pass order, mis-ordered bit lanes within a word, or a wrong plane selection.

The pulse that ends a frame is checked against the exact cycle after the final word is taken. A late, early or doubled pulse would miss that cycle or appear where none is allowed. One frame alternates all-ones and all-zero words, which catches planes that are stuck or swapped.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int IN_W   = 8;
  localparam int OUT_W  = 32;
  localparam int PLANES = IN_W;

  function automatic int ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bpt_plane_bank.sv
module bpt_plane_bank
  import bpt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = ptr_w(DEPTH),
  localparam int WW   = DEPTH / OUT_W,
  localparam int WAW  = ptr_w(WW)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [IN_W-1:0]  wdata,
  input  logic [2:0]       rplane,
  input  logic [WAW-1:0]   rword,
  output logic [OUT_W-1:0] rdata
);
  logic [DEPTH-1:0] plane_q [PLANES];

  // each plane takes one bit of the input word at the shared bit address
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (we) plane_q[p][waddr] <= wdata[p];
    end
  end

  // a read gathers 32 neighbouring bits from the selected plane
  assign rdata = plane_q[rplane][{rword, 5'b0} +: OUT_W];
endmodule

// File: rtl/bpt_wr_side.sv
module bpt_wr_side
  import bpt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = ptr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          swap,
  output logic          full,
  output logic          we,
  output logic [AW-1:0] waddr
);
  assign we = in_valid & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      waddr <= '0;
    end else if (swap) begin
      full <= 1'b0;
    end else if (we) begin
      if (waddr == AW'(DEPTH - 1)) begin
        waddr <= '0;
        full  <= 1'b1;
      end else begin
        waddr <= waddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bpt_rd_side.sv
module bpt_rd_side
  import bpt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int WW   = DEPTH / OUT_W,
  localparam int WAW  = ptr_w(WW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             out_ready,
  input  logic [OUT_W-1:0] rdata,
  output logic [2:0]       rplane,
  output logic [WAW-1:0]   rword,
  output logic             busy,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             frame_done
);
  logic [2:0] pass_q;
  logic       issued_all;
  logic       out_last;
  logic       fetch;
  logic       accept;
  logic       at_end;

  assign rplane = 3'd7 - pass_q;
  assign accept = out_valid & out_ready;
  assign fetch  = busy & ~issued_all & (~out_valid | out_ready);
  assign at_end = (pass_q == 3'd7) && (rword == WAW'(WW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      issued_all <= 1'b0;
      pass_q     <= '0;
      rword      <= '0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_data   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= accept & out_last;
      if (start) begin
        busy       <= 1'b1;
        issued_all <= 1'b0;
        pass_q     <= '0;
        rword      <= '0;
      end else begin
        if (fetch) begin
          out_data  <= rdata;
          out_valid <= 1'b1;
          out_last  <= at_end;
          if (at_end) issued_all <= 1'b1;
          if (rword == WAW'(WW - 1)) begin
            rword  <= '0;
            pass_q <= pass_q + 1'b1;
          end else begin
            rword <= rword + 1'b1;
          end
        end else if (accept) begin
          out_valid <= 1'b0;
        end
        if (accept && out_last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitplane_transposer.sv
module bitplane_transposer
  import bpt_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        frame_done
);
  localparam int AW  = ptr_w(DEPTH);
  localparam int WW  = DEPTH / OUT_W;
  localparam int WAW = ptr_w(WW);

  logic             wr_full, wr_we, rd_busy, swap, wr_bank;
  logic [AW-1:0]    waddr;
  logic [2:0]       rplane;
  logic [WAW-1:0]   rword;
  logic [OUT_W-1:0] bank_rdata [2];

  assign swap     = wr_full & ~rd_busy;
  assign in_ready = ~wr_full;

  always_ff @(posedge clk) begin
    if (rst)       wr_bank <= 1'b0;
    else if (swap) wr_bank <= ~wr_bank;
  end

  bpt_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .swap(swap),
    .full(wr_full), .we(wr_we), .waddr(waddr)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    bpt_plane_bank #(.DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(wr_we && (wr_bank == 1'(g))), .waddr(waddr),
      .wdata(in_data), .rplane(rplane), .rword(rword),
      .rdata(bank_rdata[g])
    );
  end

  bpt_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .start(swap), .out_ready(out_ready),
    .rdata(bank_rdata[~wr_bank]), .rplane(rplane), .rword(rword),
    .busy(rd_busy), .out_valid(out_valid), .out_data(out_data),
    .frame_done(frame_done)
  );
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        frame_done
);
  localparam int LAST_OUT = 8 * (DEPTH / 32) - 1;

  int  wcnt;
  int  rcnt;
  logic wacc, racc;
  assign wacc = in_valid & in_ready;
  assign racc = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= 0;
      rcnt <= 0;
    end else begin
      if (wacc) wcnt <= (wcnt == DEPTH - 1) ? 0 : wcnt + 1;
      if (racc) rcnt <= (rcnt == LAST_OUT) ? 0 : rcnt + 1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid && !frame_done));

  a_r4_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (wacc && wcnt == DEPTH - 1) |=> !in_ready);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  a_r7_after_last: assert property (@(posedge clk) disable iff (rst)
    (racc && rcnt == LAST_OUT) |=> frame_done);

  a_r7_only_after_last: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (rcnt == 0 && $past(racc)));
endmodule

bind bitplane_transposer bpt_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_bitplane_transposer.sv
module test_bitplane_transposer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int WW         = DEPTH / 32;
  localparam int NF         = 6;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        frame_done;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int overlap = 0;
  int frames_out = 0;
  logic cons_done = 1'b0;
  logic wd_expired = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= LIMIT) wd_expired <= 1'b1;
  end

  bitplane_transposer #(.DEPTH(DEPTH)) i_bitplane_transposer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_done(frame_done)
  );

  function automatic logic [7:0] pat(input int f, input int i);
    if (f == 4) return (i % 2 == 1) ? 8'hFF : 8'h00;
    return 8'((i * 29 + f * 83 + (i / 4) * 7 + 3) % 256);
  endfunction

  function automatic logic [31:0] expword(input int f, input int o);
    logic [31:0] r;
    logic [7:0]  w;
    int b, k;
    b = 7 - o / WW;
    k = o % WW;
    for (int j = 0; j < 32; j++) begin
      w = pat(f, 32 * k + j);
      r[j] = w[b];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // back-pressure snapshot with both buffers occupied
  initial begin
    wait (cyc == 250);
    @(negedge clk);
    check("R4 in_ready low while both buffers held", 32'(in_ready), 32'd0);
    check("R6 out_valid held under stall", 32'(out_valid), 32'd1);
    check("R6 out_data held as frame 0 word 0", out_data, expword(0, 0));
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 in_ready in reset", 32'(in_ready), 32'd1);
    check("R1 out_valid in reset", 32'(out_valid), 32'd0);
    check("R1 frame_done in reset", 32'(frame_done), 32'd0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    fork
      begin : producer
        int f = 0;
        int i = 0;
        while (f < NF) begin
          @(posedge clk); #1;
          in_valid = (cyc % 4 != 1) || (f >= 3);
          in_data  = pat(f, i);
          @(negedge clk);
          if (in_valid && in_ready) begin
            if (out_valid && out_ready) overlap++;
            i++;
            if (i == DEPTH) begin i = 0; f++; end
          end
        end
        @(posedge clk); #1 in_valid = 1'b0;
      end
      begin : consumer
        int fo = 0;
        int o = 0;
        logic pend = 1'b0;
        while (fo < NF) begin
          @(posedge clk); #1;
          out_ready = (cyc < 300) ? 1'b0 : (cyc < 900) ? (cyc % 3 != 0) : 1'b1;
          @(negedge clk);
          if (pend) check("R7 frame_done after last word", 32'(frame_done), 32'd1);
          else if (frame_done) check("R7 stray frame_done", 32'(frame_done), 32'd0);
          pend = 1'b0;
          if (out_valid && out_ready) begin
            check($sformatf("R2 R3 frame %0d word %0d", fo, o), out_data, expword(fo, o));
            o++;
            if (o == 8 * WW) begin o = 0; fo++; pend = 1'b1; frames_out++; end
          end
        end
        @(posedge clk);
        @(negedge clk);
        check("R7 frame_done after final frame", 32'(frame_done), 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R7 frame_done lasts one cycle", 32'(frame_done), 32'd0);
        cons_done = 1'b1;
      end
    join_none
  end

  initial begin
    wait (cons_done || wd_expired);
    if (!cons_done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end else begin
      check("R5 frames delivered", 32'(frames_out), 32'(NF));
      check("R5 writes during readout", 32'(overlap > 0), 32'd1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule